// File: doc/BRIEF.md
# Load/Store Multiple Address Sequencer

This block turns one block-transfer request into a run of single-word memory accesses. A request carries a 16-bit register-select mask, a 32-bit base address, an address mode, a load/store select and a writeback enable. The sequencer visits the selected registers from the lowest number to the highest. For each one it issues one word access over a valid/ready request channel. Store data comes from a register-file read port that the sequencer indexes. Load data returns on a response strobe and is written through a register-file write port.

Two address modes exist. In increment-after mode the first access uses the base and each later access is 4 bytes higher. In decrement-before mode the block first moves the base down by four bytes per selected register and then ascends from there. In both modes the lowest-numbered register gets the lowest address. When the run ends, the block pulses `done` and presents the moved base for writeback. It asserts `wb_en` only when the request asked for writeback. A loaded value for the highest register (the program counter) must have bit 0 set. If it does, the word is written with bit 0 cleared and a branch is flagged. If it does not, a fault is flagged and the write is suppressed.

The controller has four states. IDLE waits for a start. ISSUE presents a request. AWAIT waits for load data. FINISH reports completion. The transitions are as follows. IDLE goes to ISSUE on a start with a non-empty mask. ISSUE goes to AWAIT on an accepted load. ISSUE stays in ISSUE on an accepted store that leaves registers to do, and goes to FINISH on the final store. AWAIT goes back to ISSUE on a response that leaves registers to do, and goes to FINISH on the final response. FINISH always returns to IDLE.

Top module: `lsm_seq`

## Requirements
- R1: One memory request is issued per selected mask bit. The requests come in ascending register order, with `rf_rd_idx` giving the register number of each request. The lowest-numbered register always receives the lowest address.
- R2: In increment-after mode (`start_mode`=0) with n selected registers, the request addresses are base, base+4, ..., base+4*(n-1).
- R3: In decrement-before mode (`start_mode`=1), the request addresses are base-4*n, base-4*(n-1), ..., base-4, in that order.
- R4: A store (`start_load`=0) drives `mem_req_write`=1 with `mem_req_wdata` equal to `rf_rd_data` for the register named on `rf_rd_idx`. A load drives `mem_req_write`=0 and writes the returned word to that register in the cycle `mem_rsp_valid` is high. At all other times `rf_wr_en` stays low.
- R5: A start with an all-zero mask is illegal. It produces no request and leaves `busy` low. It raises `illegal` for exactly the cycle after the start.
- R6: `done` is high for one cycle. That cycle follows the cycle in which the final store was accepted or the final load response arrived. `wb_en` is high with `done` only if `start_wb` was set, and `wb_value` is then base+4*n (increment-after) or base-4*n (decrement-before).
- R7: `busy` rises the cycle after an accepted start and stays high through the `done` cycle. A start that arrives while `busy` is high is ignored. No request is issued while `busy` is low.
- R8: On a load of register 15, if bit 0 of the returned word is 1, the register is written with bit 0 cleared and `pc_branch` pulses. If bit 0 is 0, `pc_fault` pulses and no register write occurs.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the address, direction and register index stay unchanged. At most one load is outstanding.
- R10: After reset `busy`, `illegal`, `mem_req_valid`, `rf_wr_en` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Start request strobe |
| start_mask | input | 16 | Register-select mask, bit i selects register i |
| start_base | input | 32 | Base address |
| start_mode | input | 1 | 0 increment-after, 1 decrement-before |
| start_load | input | 1 | 1 load, 0 store |
| start_wb | input | 1 | Base writeback enable |
| busy | output | 1 | Sequence in progress |
| illegal | output | 1 | Empty-mask start seen (one cycle) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_addr | output | 32 | Word address of the request |
| mem_req_write | output | 1 | 1 store, 0 load |
| mem_req_wdata | output | 32 | Store data |
| mem_rsp_valid | input | 1 | Load data valid |
| mem_rsp_rdata | input | 32 | Load data |
| rf_rd_idx | output | 4 | Register being transferred |
| rf_rd_data | input | 32 | Register-file read data for `rf_rd_idx` |
| rf_wr_en | output | 1 | Register-file write enable |
| rf_wr_idx | output | 4 | Register-file write index |
| rf_wr_data | output | 32 | Register-file write data |
| pc_branch | output | 1 | Valid program-counter load (one cycle) |
| pc_fault | output | 1 | Program-counter load with bit 0 clear (one cycle) |
| done | output | 1 | Sequence complete (one cycle) |
| wb_en | output | 1 | Base writeback strobe |
| wb_value | output | 32 | Updated base value |

## Verification
Request fields and register-file write outputs are combinational in the cycle they belong to. The bench therefore compares them at the falling edge before the rising edge that consumes them. `illegal`, `busy` and `done` come from registers and are expected one edge after their cause: after the start, after the final accepted store, or after the final load response. The reference model schedules each of these expectations for the following falling edge. Memory-side `mem_req_ready` patterns and response latencies of zero to two cycles are varied, so that stalls test the R9 hold rule and the R6 completion timing.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_AWAIT  = 2'd2,
        ST_FINISH = 2'd3
    } lsm_state_e;

    typedef enum logic {
        AM_INC_AFTER  = 1'b0,
        AM_DEC_BEFORE = 1'b1
    } lsm_amode_e;

endpackage

// File: rtl/lsm_lowest_set.sv
module lsm_lowest_set #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx
);

    logic [N:0]   seen;
    logic [N-1:0] first;

    assign seen[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_chain
            assign seen[g+1] = seen[g] | vec[g];
            assign first[g]  = vec[g] & ~seen[g];
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (first[i]) idx = idx | IW'(i);
        end
    end

endmodule

// File: rtl/lsm_popcount.sv
module lsm_popcount #(
    parameter int N  = 16,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  vec,
    output logic [CW-1:0] cnt
);

    always_comb begin
        cnt = '0;
        for (int i = 0; i < N; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end

endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
    import lsm_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_valid,
    input  logic [NREG-1:0]         start_mask,
    input  logic [AW-1:0]           start_base,
    input  logic                    start_mode,
    input  logic                    start_load,
    input  logic                    start_wb,
    output logic                    busy,
    output logic                    illegal,
    output logic                    mem_req_valid,
    input  logic                    mem_req_ready,
    output logic [AW-1:0]           mem_req_addr,
    output logic                    mem_req_write,
    output logic [DW-1:0]           mem_req_wdata,
    input  logic                    mem_rsp_valid,
    input  logic [DW-1:0]           mem_rsp_rdata,
    output logic [$clog2(NREG)-1:0] rf_rd_idx,
    input  logic [DW-1:0]           rf_rd_data,
    output logic                    rf_wr_en,
    output logic [$clog2(NREG)-1:0] rf_wr_idx,
    output logic [DW-1:0]           rf_wr_data,
    output logic                    pc_branch,
    output logic                    pc_fault,
    output logic                    done,
    output logic                    wb_en,
    output logic [AW-1:0]           wb_value
);

    localparam int              IW     = $clog2(NREG);
    localparam int              CW     = $clog2(NREG + 1);
    localparam logic [AW-1:0]   STEP   = AW'(BYTES);
    localparam logic [IW-1:0]   PC_IDX = IW'(NREG - 1);
    localparam logic [NREG-1:0] ONE    = NREG'(1);

    lsm_state_e      state_q, state_d;
    logic [NREG-1:0] mask_q;
    logic [AW-1:0]   addr_q;
    logic [AW-1:0]   wbval_q;
    logic            wb_q;
    logic            load_q;
    logic            illegal_q;

    logic [CW-1:0]   start_cnt;
    logic [AW-1:0]   span;
    logic [IW-1:0]   cur_idx;
    logic [NREG-1:0] mask_clr;
    logic            last_beat;
    logic            start_ok;
    logic            start_bad;
    logic            beat_done;
    logic            is_pc;
    logic            pc_bad;

    // ---------------------------------------------------------------
    // Helpers: selected-register count and next register to visit
    // ---------------------------------------------------------------
    lsm_popcount #(.N(NREG), .CW(CW)) u_count (
        .vec (start_mask),
        .cnt (start_cnt)
    );

    lsm_lowest_set #(.N(NREG), .IW(IW)) u_pick (
        .vec (mask_q),
        .idx (cur_idx)
    );

    assign span      = AW'(start_cnt) * STEP;
    assign mask_clr  = mask_q & ~(ONE << cur_idx);
    assign last_beat = (mask_clr == '0);
    assign start_ok  = start_valid && (state_q == ST_IDLE) && (start_mask != '0);
    assign start_bad = start_valid && (state_q == ST_IDLE) && (start_mask == '0);
    assign is_pc     = (cur_idx == PC_IDX);
    assign pc_bad    = is_pc && !mem_rsp_rdata[0];
    assign beat_done = ((state_q == ST_ISSUE) && mem_req_ready && !load_q) ||
                       ((state_q == ST_AWAIT) && mem_rsp_valid);

    // ---------------------------------------------------------------
    // Next-state logic
    // ---------------------------------------------------------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ok) state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (mem_req_ready) begin
                    if (load_q)         state_d = ST_AWAIT;
                    else if (last_beat) state_d = ST_FINISH;
                    else                state_d = ST_ISSUE;
                end
            end
            ST_AWAIT: begin
                if (mem_rsp_valid) state_d = last_beat ? ST_FINISH : ST_ISSUE;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // ---------------------------------------------------------------
    // State register
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------------------------------------------------------
    // Sequence datapath registers
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q    <= '0;
            addr_q    <= '0;
            wbval_q   <= '0;
            wb_q      <= 1'b0;
            load_q    <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= start_bad;
            if (start_ok) begin
                mask_q <= start_mask;
                load_q <= start_load;
                wb_q   <= start_wb;
                if (lsm_amode_e'(start_mode) == AM_DEC_BEFORE) begin
                    addr_q  <= start_base - span;
                    wbval_q <= start_base - span;
                end else begin
                    addr_q  <= start_base;
                    wbval_q <= start_base + span;
                end
            end else if (beat_done) begin
                mask_q <= mask_clr;
                addr_q <= addr_q + STEP;
            end
        end
    end

    // ---------------------------------------------------------------
    // Outputs
    // ---------------------------------------------------------------
    always_comb begin
        busy          = (state_q != ST_IDLE);
        illegal       = illegal_q;
        mem_req_valid = (state_q == ST_ISSUE);
        mem_req_addr  = addr_q;
        mem_req_write = !load_q;
        mem_req_wdata = rf_rd_data;
        rf_rd_idx     = cur_idx;
        rf_wr_en      = (state_q == ST_AWAIT) && mem_rsp_valid && !pc_bad;
        rf_wr_idx     = cur_idx;
        rf_wr_data    = is_pc ? (mem_rsp_rdata & ~DW'(1)) : mem_rsp_rdata;
        pc_branch     = (state_q == ST_AWAIT) && mem_rsp_valid && is_pc && mem_rsp_rdata[0];
        pc_fault      = (state_q == ST_AWAIT) && mem_rsp_valid && pc_bad;
        done          = (state_q == ST_FINISH);
        wb_en         = (state_q == ST_FINISH) && wb_q;
        wb_value      = wbval_q;
    end

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
        $stable(rf_rd_idx) && $stable(mem_req_write)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid && !rf_wr_en); // R7

    AST_ILLEGAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !busy && !mem_req_valid); // R5

    AST_PC_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en && (rf_wr_idx == PC_IDX) |-> !rf_wr_data[0]); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy); // R6

    AST_NO_REQ_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready && !mem_req_write |=> !mem_req_valid); // R9

endmodule

// File: tb/tb_lsm_seq.sv
module tb_lsm_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_valid = 1'b0;
    logic [15:0] start_mask = '0;
    logic [31:0] start_base = '0;
    logic        start_mode = 1'b0;
    logic        start_load = 1'b0;
    logic        start_wb = 1'b0;
    logic        busy, illegal, mem_req_valid, mem_req_write;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic [3:0]  rf_rd_idx, rf_wr_idx;
    logic [31:0] rf_rd_data, rf_wr_data, wb_value;
    logic        rf_wr_en, pc_branch, pc_fault, done, wb_en;

    always #2.5 clk = ~clk;

    lsm_seq dut (
        .clk(clk), .rst_n(rst_n),
        .start_valid(start_valid), .start_mask(start_mask), .start_base(start_base),
        .start_mode(start_mode), .start_load(start_load), .start_wb(start_wb),
        .busy(busy), .illegal(illegal),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_write(mem_req_write),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
        .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
        .pc_branch(pc_branch), .pc_fault(pc_fault),
        .done(done), .wb_en(wb_en), .wb_value(wb_value)
    );

    // bench-side register file and memory
    logic [31:0] rf  [16];
    logic [31:0] mem [1024];
    assign rf_rd_data = rf[rf_rd_idx];

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // reference model state
    logic [31:0] q_addr[$];
    int          q_idx[$];
    bit          m_busy = 0, m_load = 0, m_dec = 0;
    bit          exp_ill = 0, exp_done = 0, exp_wben = 0;
    logic [31:0] exp_wbval = '0;
    bit          pend = 0;
    int          pend_wait = 0, pend_idx = 0, cur_ridx = 0;
    logic [31:0] pend_data = '0;
    int          rdy_mode = 0, rsp_lat = 0;
    logic        nxt_ready = 1'b1, nxt_rsp_valid = 1'b0;
    logic [31:0] nxt_rdata = '0;

    always @(posedge clk) begin
        #1;
        mem_req_ready = nxt_ready;
        mem_rsp_valid = nxt_rsp_valid;
        mem_rsp_rdata = nxt_rdata;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit          done_n;
            bit          keep_busy;
            logic [31:0] a;
            int          ix;
            logic [31:0] d;
            string       atag;
            cyc++;
            done_n = 0;
            atag = m_dec ? "R3" : "R2";
            chk(busy === m_busy, "R7 busy", 32'(busy), 32'(m_busy));
            chk(illegal === exp_ill, "R5 illegal", 32'(illegal), 32'(exp_ill));
            chk(done === exp_done, "R6 done", 32'(done), 32'(exp_done));
            if (exp_done) begin
                chk(wb_en === exp_wben, "R6 wb_en", 32'(wb_en), 32'(exp_wben));
                if (exp_wben) chk(wb_value === exp_wbval, "R6 wb_value", wb_value, exp_wbval);
            end else begin
                chk(wb_en === 1'b0, "R6 wb_en idle", 32'(wb_en), 32'd0);
            end
            if (!m_busy) chk(mem_req_valid === 1'b0, "R7 req while idle", 32'(mem_req_valid), 32'd0);
            // request channel
            if (mem_req_valid && mem_req_ready) begin
                if (q_addr.size() == 0) begin
                    chk(1'b0, "R1 extra request", mem_req_addr, 32'hFFFF_FFFF);
                end else begin
                    a  = q_addr.pop_front();
                    ix = q_idx.pop_front();
                    chk(mem_req_addr === a, atag, mem_req_addr, a);
                    chk(rf_rd_idx === 4'(ix), "R1 order", 32'(rf_rd_idx), 32'(ix));
                    chk(mem_req_write === !m_load, "R4 dir", 32'(mem_req_write), 32'(!m_load));
                    if (!m_load) begin
                        chk(mem_req_wdata === rf[ix], "R4 wdata", mem_req_wdata, rf[ix]);
                        mem[a[11:2]] = mem_req_wdata;
                        if (q_addr.size() == 0) done_n = 1;
                    end else begin
                        pend = 1; pend_wait = rsp_lat; pend_idx = ix; pend_data = mem[a[11:2]];
                    end
                end
            end
            // response / register write side
            if (mem_rsp_valid) begin
                d = mem_rsp_rdata;
                if (cur_ridx == 15 && !d[0]) begin
                    chk(pc_fault === 1'b1, "R8 fault", 32'(pc_fault), 32'd1);
                    chk(rf_wr_en === 1'b0, "R8 no write", 32'(rf_wr_en), 32'd0);
                    chk(pc_branch === 1'b0, "R8 no branch", 32'(pc_branch), 32'd0);
                end else begin
                    if (cur_ridx == 15) d[0] = 1'b0;
                    chk(rf_wr_en === 1'b1, "R4 wr_en", 32'(rf_wr_en), 32'd1);
                    chk(rf_wr_idx === 4'(cur_ridx), "R4 wr_idx", 32'(rf_wr_idx), 32'(cur_ridx));
                    chk(rf_wr_data === d, (cur_ridx == 15) ? "R8 data" : "R4 data", rf_wr_data, d);
                    chk(pc_branch === (cur_ridx == 15), "R8 branch", 32'(pc_branch), 32'(cur_ridx == 15));
                    chk(pc_fault === 1'b0, "R8 fault clear", 32'(pc_fault), 32'd0);
                    rf[cur_ridx] = d;
                end
                if (q_addr.size() == 0) done_n = 1;
            end else begin
                chk(!rf_wr_en && !pc_fault && !pc_branch, "R4 quiet write port",
                    {29'd0, rf_wr_en, pc_fault, pc_branch}, 32'd0);
            end
            // start acceptance
            keep_busy = m_busy;
            exp_ill = 0;
            if (exp_done) m_busy = 0;
            if (start_valid && !keep_busy) begin
                if (start_mask == 16'd0) begin
                    exp_ill = 1;
                end else begin
                    int          n;
                    logic [31:0] lo;
                    n = 0;
                    for (int r = 0; r < 16; r++) if (start_mask[r]) n++;
                    lo = start_mode ? start_base - 32'(4 * n) : start_base;
                    exp_wbval = start_mode ? start_base - 32'(4 * n) : start_base + 32'(4 * n);
                    exp_wben = start_wb;
                    m_load = start_load;
                    m_dec = start_mode;
                    n = 0;
                    for (int r = 0; r < 16; r++) begin
                        if (start_mask[r]) begin
                            q_addr.push_back(lo + 32'(4 * n));
                            q_idx.push_back(r);
                            n++;
                        end
                    end
                    m_busy = 1;
                end
            end
            exp_done = done_n;
            // memory-side drive for the next cycle
            nxt_rsp_valid = 1'b0;
            if (pend) begin
                if (pend_wait == 0) begin
                    nxt_rsp_valid = 1'b1; nxt_rdata = pend_data; cur_ridx = pend_idx; pend = 0;
                end else begin
                    pend_wait--;
                end
            end
            case (rdy_mode)
                0:       nxt_ready = 1'b1;
                1:       nxt_ready = cyc[0];
                default: nxt_ready = (cyc % 3 == 0);
            endcase
            if (cyc > 20000) begin
                chk(1'b0, "watchdog", 32'(cyc), 32'd20000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    task automatic launch(input logic [15:0] m, input logic [31:0] b, input bit dec,
                          input bit ld, input bit wb);
        @(posedge clk); #1;
        start_valid = 1'b1; start_mask = m; start_base = b;
        start_mode = dec; start_load = ld; start_wb = wb;
        @(posedge clk); #1;
        start_valid = 1'b0;
    endtask

    task automatic settle();
        do @(negedge clk); while (busy);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) rf[i] = 32'hF000_0000 | (i * 32'h111);
        for (int i = 0; i < 1024; i++) mem[i] = 32'hC0DE_0000 + i * 3;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(busy === 1'b0, "R10 busy", 32'(busy), 0);
        chk(mem_req_valid === 1'b0, "R10 req", 32'(mem_req_valid), 0);
        chk(done === 1'b0 && illegal === 1'b0, "R10 done/illegal", 32'(done | illegal), 0);
        chk(rf_wr_en === 1'b0, "R10 wr_en", 32'(rf_wr_en), 0);
        @(posedge clk); #1 rst_n = 1'b1;

        rdy_mode = 0; rsp_lat = 0;
        launch(16'h00A5, 32'h0000_0100, 1'b0, 1'b0, 1'b1);   // R2 store IA
        settle();
        rdy_mode = 1; rsp_lat = 1;
        launch(16'h0F00, 32'h0000_0200, 1'b1, 1'b1, 1'b1);   // R3 load DB
        settle();
        rdy_mode = 2; rsp_lat = 2;
        launch(16'h8003, 32'h0000_0304, 1'b0, 1'b1, 1'b0);   // R8 branch
        settle();
        rdy_mode = 0; rsp_lat = 0;
        launch(16'h8000, 32'h0000_0404, 1'b1, 1'b1, 1'b1);   // R8 fault
        settle();
        launch(16'h0000, 32'h0000_0500, 1'b0, 1'b0, 1'b1);   // R5 empty mask
        settle();
        rdy_mode = 1;
        launch(16'h0030, 32'h0000_0600, 1'b0, 1'b0, 1'b1);   // R7 ignore test
        launch(16'h0F0F, 32'h0000_0700, 1'b1, 1'b1, 1'b1);   // arrives while busy
        settle();
        rdy_mode = 2;
        launch(16'hFFFF, 32'h0000_0080, 1'b1, 1'b0, 1'b0);   // R3 full mask, no writeback
        settle();
        rdy_mode = 0; rsp_lat = 1;
        launch(16'h0001, 32'h0000_0800, 1'b0, 1'b1, 1'b1);   // R1 single register
        settle();
        launch(16'hFFFF, 32'h0000_0000, 1'b0, 1'b1, 1'b1);   // R1 full mask load IA
        settle();
        chk(q_addr.size() == 0, "R1 all beats issued", 32'(q_addr.size()), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule